// File: doc/BRIEF.md
# MESI Snooping Cache-Line Controller

This block keeps the coherence state of every line in one private write-back cache attached to a shared snooping bus. It has a small direct-mapped array. Each entry holds a tag, a two-bit state and a single data word that stands in for the whole line. The processor side presents one read or write at a time. The block answers a hit at once. On a miss or an upgrade it raises a bus request, waits for the grant and completes in the cycle after the grant. A Modified victim is written back before the fetch.

On the bus side the block watches every transaction that other caches own. A read or read-to-own that hits a valid line raises `snp_hit`, which the system ORs into the shared signal. The line then drops to Shared or Invalid. When no lower-numbered cache holds the line (`snp_prio_in` low), the block also drives the line's word as the cache-to-cache supplier. Several copies of the block, one per cache, sit on one bus model. An external arbiter grants one transaction per cycle. Memory takes the data of every flush and every write-back.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `cpu_done`, `bus_req`, `snp_hit` and `snp_flush` are low. An address splits into an index (the low log2(LINES) bits) and a tag (the remaining high bits). Bus command codes are 0 none, 1 read, 2 read-to-own, 3 write-back.
- R2: A read that misses requests a bus read (code 1) for the request address. The line is filled from `bus_data_in` in the grant cycle. It is installed Exclusive if `bus_shared_in` is low and Shared if it is high. `cpu_done` is high with the data in the cycle after the grant.
- R3: A write to an Invalid or Shared line requests a read-to-own (code 2). The line becomes Modified and holds the written word, and `cpu_done` rises in the cycle after the grant.
- R4: Reads that hit Shared, Exclusive or Modified, and writes that hit Exclusive or Modified, finish in the request cycle with no bus request. A write to Exclusive silently makes the line Modified, so a later snoop supplies the written word.
- R5: A miss whose indexed line is Modified with another tag first issues a write-back (code 3) with the victim's address and word. The fetch follows in the next cycle. A victim that is not Modified is replaced without a write-back.
- R6: A snooped read that hits a valid line raises `snp_hit`, and the line becomes Shared.
- R7: A snooped read-to-own that hits a valid line raises `snp_hit`, and the line becomes Invalid.
- R8: On a snoop hit, `snp_flush` rises and `snp_data` carries the line's word only when `snp_prio_in` is low. Among several sharers, only the lowest-numbered one supplies.
- R9: A snooped read or read-to-own to the index of a request waiting in idle stalls that request for the cycle (`cpu_done` low). The request then proceeds against the line's state after the snoop.
- R10: The block never snoops its own granted transaction, and it ignores snooped write-backs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_done | output | 1 | Request complete this cycle |
| cpu_rdata | output | DATA_W | Line word, valid with `cpu_done` |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 2 | Command of the wanted transaction |
| bus_addr | output | ADDR_W | Address of the wanted transaction |
| bus_wdata | output | DATA_W | Write-back word |
| bus_gnt | input | 1 | This cache owns the bus this cycle |
| bus_valid | input | 1 | A transaction is on the bus |
| bus_cmd_in | input | 2 | Command on the bus |
| bus_addr_in | input | ADDR_W | Address on the bus |
| bus_data_in | input | DATA_W | Resolved data (supplier or memory) |
| bus_shared_in | input | 1 | Wired OR of all snoop hits |
| snp_prio_in | input | 1 | A lower-numbered cache also hits |
| snp_hit | output | 1 | This cache holds the snooped line valid |
| snp_flush | output | 1 | This cache supplies the snooped line |
| snp_data | output | DATA_W | Supplied word |

## Verification
A snoop from another cache's transaction and a local processor request can fall on the same index in the same cycle. This is provoked by letting a cache hold a line Exclusive and having a second cache start a write to it. The first cache's read is raised exactly in the cycle the read-to-own is on the bus. The bench expects the snoop to win: the first cache flushes, invalidates and reports no completion that cycle. One cycle later it treats its read as a miss, fetches the new word from the owner and both end Shared. Every other operation is predicted by a behavioural model that tracks state, tag and word per cache and compares bus and processor outputs each cycle.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

   typedef enum logic [1:0] {
      LS_I = 2'd0,
      LS_S = 2'd1,
      LS_E = 2'd2,
      LS_M = 2'd3
   } line_st_t;

   typedef enum logic [1:0] {
      BC_NONE = 2'd0,
      BC_RD   = 2'd1,
      BC_RDX  = 2'd2,
      BC_WB   = 2'd3
   } bus_cmd_t;

   typedef enum logic [1:0] {
      RQ_IDLE   = 2'd0,
      RQ_EVICT  = 2'd1,
      RQ_FETCH  = 2'd2,
      RQ_FINISH = 2'd3
   } req_st_t;

endpackage

// File: rtl/mesi_tag_array.sv
module mesi_tag_array
   import mesi_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int TAG_W  = 9,
   parameter int DATA_W = 16,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   // local read port
   input  logic [IDX_W-1:0]  a_idx,
   output logic [TAG_W-1:0]  a_tag,
   output line_st_t          a_st,
   output logic [DATA_W-1:0] a_data,
   // snoop read port
   input  logic [IDX_W-1:0]  b_idx,
   output logic [TAG_W-1:0]  b_tag,
   output line_st_t          b_st,
   output logic [DATA_W-1:0] b_data,
   // snoop state write, at b_idx
   input  logic              s_we,
   input  line_st_t          s_st,
   // local full write
   input  logic              l_we,
   input  logic [IDX_W-1:0]  l_idx,
   input  logic [TAG_W-1:0]  l_tag,
   input  line_st_t          l_st,
   input  logic [DATA_W-1:0] l_data
);

   logic [TAG_W-1:0]  tag_q  [LINES];
   line_st_t          st_q   [LINES];
   logic [DATA_W-1:0] data_q [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) begin
            tag_q[i]  <= '0;
            st_q[i]   <= LS_I;
            data_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < LINES; i++) begin
            if (l_we && l_idx == IDX_W'(i)) begin
               tag_q[i]  <= l_tag;
               st_q[i]   <= l_st;
               data_q[i] <= l_data;
            end else if (s_we && b_idx == IDX_W'(i)) begin
               st_q[i] <= s_st;
            end
         end
      end
   end

   assign a_tag  = tag_q[a_idx];
   assign a_st   = st_q[a_idx];
   assign a_data = data_q[a_idx];
   assign b_tag  = tag_q[b_idx];
   assign b_st   = st_q[b_idx];
   assign b_data = data_q[b_idx];

   // R9: the stall rule keeps the two writers off the same entry
   assert_no_port_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_we && l_we && (b_idx == l_idx)));

   // R6, R7: a snoop only demotes a line
   assert_snoop_demotes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      s_we |-> (s_st == LS_S || s_st == LS_I));

endmodule

// File: rtl/mesi_snoop.sv
module mesi_snoop
   import mesi_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int IDX_W     = 3,
   parameter int TAG_W     = 9,
   parameter int DATA_W    = 16,
   parameter bit GATE_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_gnt,
   input  logic [1:0]        bus_cmd_in,
   input  logic [ADDR_W-1:0] bus_addr_in,
   input  logic              snp_prio_in,
   output logic [IDX_W-1:0]  look_idx,
   input  logic [TAG_W-1:0]  look_tag,
   input  line_st_t          look_st,
   input  logic [DATA_W-1:0] look_data,
   output logic              snp_active,
   output logic              snp_hit,
   output logic              snp_flush,
   output logic [DATA_W-1:0] snp_data,
   output logic              s_we,
   output line_st_t          s_st
);

   bus_cmd_t          cmd;
   logic [TAG_W-1:0]  bus_tag;

   assign cmd      = bus_cmd_t'(bus_cmd_in);
   assign look_idx = bus_addr_in[IDX_W-1:0];
   assign bus_tag  = bus_addr_in[ADDR_W-1:IDX_W];

   // foreign read or read-to-own only; write-backs pass unseen
   assign snp_active = bus_valid && !bus_gnt && (cmd == BC_RD || cmd == BC_RDX);
   assign snp_hit    = snp_active && (look_st != LS_I) && (look_tag == bus_tag);
   assign snp_flush  = snp_hit && !snp_prio_in;
   assign s_we       = snp_hit;
   assign s_st       = (cmd == BC_RD) ? LS_S : LS_I;

   generate
      if (GATE_DATA) begin : g_gated
         assign snp_data = snp_flush ? look_data : '0;
      end else begin : g_raw
         assign snp_data = look_data;
      end
   endgenerate

   // R10: never answers its own transaction
   assert_no_self_snoop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_gnt) |-> !snp_flush);

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int IDX_W  = 3,
   parameter int TAG_W  = 9,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_gnt,
   input  logic [DATA_W-1:0] bus_data_in,
   input  logic              bus_shared_in,
   input  logic              snp_active,
   input  logic [IDX_W-1:0]  snp_idx,
   output logic [IDX_W-1:0]  a_idx,
   input  logic [TAG_W-1:0]  a_tag,
   input  line_st_t          a_st,
   input  logic [DATA_W-1:0] a_data,
   output logic              l_we,
   output logic [TAG_W-1:0]  l_tag,
   output line_st_t          l_st,
   output logic [DATA_W-1:0] l_data
);

   req_st_t          cur_q, nxt;
   logic [IDX_W-1:0] cpu_idx;
   logic [TAG_W-1:0] cpu_tag;
   logic             hit, quiet_hit, conflict;

   assign cpu_idx   = cpu_addr[IDX_W-1:0];
   assign cpu_tag   = cpu_addr[ADDR_W-1:IDX_W];
   assign a_idx     = cpu_idx;
   assign hit       = (a_st != LS_I) && (a_tag == cpu_tag);
   assign quiet_hit = hit && !(cpu_we && a_st == LS_S);
   assign conflict  = snp_active && (snp_idx == cpu_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= RQ_IDLE;
      else        cur_q <= nxt;
   end

   always_comb begin
      nxt       = cur_q;
      cpu_done  = 1'b0;
      cpu_rdata = a_data;
      bus_req   = 1'b0;
      bus_cmd   = BC_NONE;
      bus_addr  = cpu_addr;
      bus_wdata = cpu_wdata;
      l_we      = 1'b0;
      l_tag     = cpu_tag;
      l_st      = a_st;
      l_data    = a_data;
      unique case (cur_q)
         RQ_IDLE: begin
            if (cpu_req && !conflict) begin
               if (quiet_hit) begin
                  cpu_done = 1'b1;
                  if (cpu_we) begin
                     l_we   = 1'b1;
                     l_st   = LS_M;
                     l_data = cpu_wdata;
                  end
               end else if (!hit && a_st == LS_M) begin
                  nxt = RQ_EVICT;
               end else begin
                  nxt = RQ_FETCH;
               end
            end
         end
         RQ_EVICT: begin
            if (a_st == LS_M && a_tag != cpu_tag) begin
               bus_req   = 1'b1;
               bus_cmd   = BC_WB;
               bus_addr  = {a_tag, cpu_idx};
               bus_wdata = a_data;
               if (bus_gnt) begin
                  l_we  = 1'b1;
                  l_tag = a_tag;
                  l_st  = LS_I;
                  nxt   = RQ_FETCH;
               end
            end else begin
               nxt = RQ_FETCH;
            end
         end
         RQ_FETCH: begin
            bus_req = 1'b1;
            bus_cmd = cpu_we ? BC_RDX : BC_RD;
            if (bus_gnt) begin
               l_we   = 1'b1;
               l_st   = cpu_we ? LS_M : (bus_shared_in ? LS_S : LS_E);
               l_data = cpu_we ? cpu_wdata : bus_data_in;
               nxt    = RQ_FINISH;
            end
         end
         RQ_FINISH: begin
            cpu_done = 1'b1;
            nxt      = RQ_IDLE;
         end
         default: nxt = RQ_IDLE;
      endcase
   end

   // R2: completion follows the granted fetch by one cycle
   assert_fill_completes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == RQ_FETCH && bus_gnt) |=> cpu_done);

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter int ADDR_W        = 12,
   parameter int DATA_W        = 16,
   parameter int LINES         = 8,
   parameter bit GATE_SNP_DATA = 1'b1,
   localparam int IDX_W        = $clog2(LINES),
   localparam int TAG_W        = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_gnt,
   input  logic              bus_valid,
   input  logic [1:0]        bus_cmd_in,
   input  logic [ADDR_W-1:0] bus_addr_in,
   input  logic [DATA_W-1:0] bus_data_in,
   input  logic              bus_shared_in,
   input  logic              snp_prio_in,
   output logic              snp_hit,
   output logic              snp_flush,
   output logic [DATA_W-1:0] snp_data
);

   generate
      if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
         $error("LINES must be a power of two of at least 2");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("ADDR_W must exceed the index width");
      end
   endgenerate

   logic [IDX_W-1:0]  a_idx, b_idx;
   logic [TAG_W-1:0]  a_tag, b_tag, l_tag;
   line_st_t          a_st, b_st, l_st, s_st;
   logic [DATA_W-1:0] a_data, b_data, l_data;
   logic              l_we, s_we, snp_active;

   mesi_tag_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
      .clk(clk), .rst_n(rst_n),
      .a_idx(a_idx), .a_tag(a_tag), .a_st(a_st), .a_data(a_data),
      .b_idx(b_idx), .b_tag(b_tag), .b_st(b_st), .b_data(b_data),
      .s_we(s_we), .s_st(s_st),
      .l_we(l_we), .l_idx(a_idx), .l_tag(l_tag), .l_st(l_st), .l_data(l_data)
   );

   mesi_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W),
                .GATE_DATA(GATE_SNP_DATA)) u_snoop (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_gnt(bus_gnt), .bus_cmd_in(bus_cmd_in),
      .bus_addr_in(bus_addr_in), .snp_prio_in(snp_prio_in),
      .look_idx(b_idx), .look_tag(b_tag), .look_st(b_st), .look_data(b_data),
      .snp_active(snp_active), .snp_hit(snp_hit), .snp_flush(snp_flush),
      .snp_data(snp_data), .s_we(s_we), .s_st(s_st)
   );

   mesi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
      .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_gnt(bus_gnt), .bus_data_in(bus_data_in), .bus_shared_in(bus_shared_in),
      .snp_active(snp_active), .snp_idx(b_idx),
      .a_idx(a_idx), .a_tag(a_tag), .a_st(a_st), .a_data(a_data),
      .l_we(l_we), .l_tag(l_tag), .l_st(l_st), .l_data(l_data)
   );

   // R3: a granted read-to-own leaves the requested line Modified
   assert_rdx_owns_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && bus_cmd == BC_RDX) |=> (a_st == LS_M));

   // R5: a granted write-back is followed at once by the fetch
   assert_wb_then_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && bus_cmd == BC_WB) |=>
      (bus_req && (bus_cmd == BC_RD || bus_cmd == BC_RDX)));

endmodule

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;

   localparam int AW = 6;
   localparam int DW = 16;
   localparam int LN = 4;
   localparam int NC = 3;
   localparam int NA = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          cpu_req   [NC];
   logic          cpu_we    [NC];
   logic [AW-1:0] cpu_addr  [NC];
   logic [DW-1:0] cpu_wdata [NC];
   logic          cpu_done  [NC];
   logic [DW-1:0] cpu_rdata [NC];
   logic          bus_req   [NC];
   logic [1:0]    bus_cmd   [NC];
   logic [AW-1:0] bus_addr  [NC];
   logic [DW-1:0] bus_wdata [NC];
   logic          gnt       [NC];
   logic          prio      [NC];
   logic          snp_hit   [NC];
   logic          snp_flush [NC];
   logic [DW-1:0] snp_data  [NC];

   logic          bvalid, bshared, bflush;
   logic [1:0]    bcmd;
   logic [AW-1:0] baddr;
   logic [DW-1:0] bwd, bdata;
   logic [DW-1:0] mem [NA];

   for (genvar g = 0; g < NC; g++) begin : g_c
      mesi_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(LN)) u0 (
         .clk(clk), .rst_n(rst_n),
         .cpu_req(cpu_req[g]), .cpu_we(cpu_we[g]), .cpu_addr(cpu_addr[g]),
         .cpu_wdata(cpu_wdata[g]), .cpu_done(cpu_done[g]), .cpu_rdata(cpu_rdata[g]),
         .bus_req(bus_req[g]), .bus_cmd(bus_cmd[g]), .bus_addr(bus_addr[g]),
         .bus_wdata(bus_wdata[g]), .bus_gnt(gnt[g]), .bus_valid(bvalid),
         .bus_cmd_in(bcmd), .bus_addr_in(baddr), .bus_data_in(bdata),
         .bus_shared_in(bshared), .snp_prio_in(prio[g]),
         .snp_hit(snp_hit[g]), .snp_flush(snp_flush[g]), .snp_data(snp_data[g])
      );
   end

   // fixed-priority arbiter: lowest requester wins
   always_comb begin
      bvalid = 1'b0; bcmd = 2'd0; baddr = '0; bwd = '0;
      for (int k = 0; k < NC; k++) begin
         gnt[k] = 1'b0;
         if (bus_req[k] && !bvalid) begin
            gnt[k] = 1'b1; bvalid = 1'b1;
            bcmd = bus_cmd[k]; baddr = bus_addr[k]; bwd = bus_wdata[k];
         end
      end
   end

   // wired-OR shared line, supplier chain, data resolution
   always_comb begin
      bshared = 1'b0; bflush = 1'b0; bdata = mem[baddr];
      for (int k = 0; k < NC; k++) begin
         prio[k] = bshared;
         bshared = bshared | snp_hit[k];
         if (snp_flush[k]) begin bflush = 1'b1; bdata = snp_data[k]; end
      end
   end

   always @(posedge clk) begin
      if (bvalid && bcmd == 2'd3) mem[baddr] <= bwd;
      if (bvalid && bflush)       mem[baddr] <= bdata;
   end

   // reference model
   int            mst  [NC][LN];   // 0 I, 1 S, 2 E, 3 M
   int            mtag [NC][LN];
   logic [DW-1:0] mdat [NC][LN];
   logic [DW-1:0] rmem [NA];
   int nvec = 0;
   int nerr = 0;
   bit ended = 0;

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic wrap_up();
      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   endtask

   task automatic idle_bus(input string what);
      for (int k = 0; k < NC; k++) chk(what, bus_req[k], 0);
   endtask

   task automatic do_op(input int c, input bit we, input int addr, input logic [DW-1:0] wd);
      int idx, tg, sup;
      bit hit, shared, holds;
      logic [DW-1:0] bd;
      idx = addr % LN;
      tg  = addr / LN;
      hit = mst[c][idx] != 0 && mtag[c][idx] == tg;
      @(negedge clk);
      cpu_req[c] = 1; cpu_we[c] = we; cpu_addr[c] = AW'(addr); cpu_wdata[c] = wd;
      #1;
      if (hit && !(we && mst[c][idx] == 1)) begin
         chk("R4 hit done", cpu_done[c], 1);
         idle_bus("R4 hit no bus");
         if (!we) chk("R4 hit data", cpu_rdata[c], mdat[c][idx]);
         else begin mst[c][idx] = 3; mdat[c][idx] = wd; end
      end else begin
         chk(we ? "R3 wait" : "R2 wait", cpu_done[c], 0);
         idle_bus("R2 idle cycle no bus");
         if (!hit && mst[c][idx] == 3) begin
            @(negedge clk); #1;
            chk("R5 wb req", bus_req[c], 1);
            chk("R5 wb cmd", bus_cmd[c], 3);
            chk("R5 wb addr", bus_addr[c], mtag[c][idx] * LN + idx);
            chk("R5 wb data", bus_wdata[c], mdat[c][idx]);
            for (int k = 0; k < NC; k++) chk("R10 wb unsnooped", snp_hit[k], 0);
            rmem[mtag[c][idx] * LN + idx] = mdat[c][idx];
            mst[c][idx] = 0;
         end
         @(negedge clk); #1;
         chk(we ? "R3 fetch req" : "R2 fetch req", bus_req[c], 1);
         chk(we ? "R3 fetch cmd" : "R2 fetch cmd", bus_cmd[c], we ? 2 : 1);
         chk("R2 fetch addr", bus_addr[c], addr);
         chk("R10 no self snoop", snp_hit[c], 0);
         sup = -1; shared = 0; bd = rmem[addr];
         for (int k = 0; k < NC; k++) begin
            if (k != c) begin
               holds = mst[k][idx] != 0 && mtag[k][idx] == tg;
               chk(we ? "R7 snoop hit" : "R6 snoop hit", snp_hit[k], holds);
               chk("R8 flush select", snp_flush[k], holds && sup < 0);
               if (holds && sup < 0) begin
                  sup = k; bd = mdat[k][idx];
                  chk("R8 flush data", snp_data[k], bd);
               end
               if (holds) begin
                  shared = 1;
                  mst[k][idx] = we ? 0 : 1;
               end
            end
         end
         if (sup >= 0) rmem[addr] = bd;
         mtag[c][idx] = tg;
         mst[c][idx]  = we ? 3 : (shared ? 1 : 2);
         mdat[c][idx] = we ? wd : bd;
         @(negedge clk); #1;
         chk(we ? "R3 done" : "R2 done", cpu_done[c], 1);
         chk(we ? "R3 line word" : "R2 fill data", cpu_rdata[c], mdat[c][idx]);
      end
      @(negedge clk);
      cpu_req[c] = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      wrap_up();
   end

   initial begin
      for (int k = 0; k < NC; k++) begin
         cpu_req[k] = 0; cpu_we[k] = 0; cpu_addr[k] = '0; cpu_wdata[k] = '0;
         for (int i = 0; i < LN; i++) begin
            mst[k][i] = 0; mtag[k][i] = 0; mdat[k][i] = '0;
         end
      end
      for (int a = 0; a < NA; a++) begin
         mem[a]  = DW'(16'h1000 + a);
         rmem[a] = DW'(16'h1000 + a);
      end
      repeat (3) @(posedge clk);
      #1;
      for (int k = 0; k < NC; k++) begin
         chk("R1 reset done", cpu_done[k], 0);
         chk("R1 reset req", bus_req[k], 0);
         chk("R1 reset hit", snp_hit[k], 0);
         chk("R1 reset flush", snp_flush[k], 0);
      end
      @(negedge clk); rst_n = 1;

      do_op(0, 0, 5, '0);            // R2 alone -> E
      do_op(1, 0, 5, '0);            // R2 shared, R6, R8 E supplies
      do_op(2, 0, 5, '0);            // R8 two sharers, lowest supplies
      do_op(0, 0, 5, '0);            // R4 S read hit
      do_op(1, 1, 5, 16'hBEEF);      // R3 upgrade from S, R7
      do_op(1, 1, 5, 16'hCAFE);      // R4 M write hit
      do_op(2, 0, 5, '0);            // R6 M owner flushes
      do_op(0, 1, 9, 16'h0909);      // R3 write miss
      do_op(0, 0, 13, '0);           // R5 write-back of dirty victim
      do_op(0, 0, 9, '0);            // R5 clean victim, no write-back
      do_op(2, 0, 2, '0);            // R2 -> E
      do_op(2, 1, 2, 16'h2222);      // R4 silent E -> M
      do_op(0, 0, 2, '0);            // R4 written word supplied
      do_op(0, 0, 7, '0);            // setup: c0 holds 7 Exclusive

      // R9: snoop and local request on one index in one cycle
      @(negedge clk);
      cpu_req[1] = 1; cpu_we[1] = 1; cpu_addr[1] = AW'(7); cpu_wdata[1] = 16'hAAAA;
      #1;
      chk("R9 t0 wait", cpu_done[1], 0);
      idle_bus("R9 t0 bus idle");
      @(negedge clk);
      cpu_req[0] = 1; cpu_we[0] = 0; cpu_addr[0] = AW'(7);
      #1;
      chk("R9 rdx on bus", bus_req[1], 1);
      chk("R9 rdx cmd", bus_cmd[1], 2);
      chk("R7 holder hits", snp_hit[0], 1);
      chk("R8 holder supplies", snp_flush[0], 1);
      chk("R9 local stalled", cpu_done[0], 0);
      chk("R9 no local bus", bus_req[0], 0);
      @(negedge clk); #1;
      chk("R9 writer done", cpu_done[1], 1);
      chk("R9 writer word", cpu_rdata[1], 16'hAAAA);
      chk("R9 reader now misses", cpu_done[0], 0);
      chk("R9 reader no bus yet", bus_req[0], 0);
      @(negedge clk);
      cpu_req[1] = 0;
      #1;
      chk("R9 reader fetch", bus_req[0], 1);
      chk("R9 reader cmd", bus_cmd[0], 1);
      chk("R6 owner hits", snp_hit[1], 1);
      chk("R8 owner flushes", snp_flush[1], 1);
      chk("R8 owner word", snp_data[1], 16'hAAAA);
      @(negedge clk); #1;
      chk("R9 reader done", cpu_done[0], 1);
      chk("R9 reader word", cpu_rdata[0], 16'hAAAA);
      @(negedge clk);
      cpu_req[0] = 0;
      mst[0][3] = 1; mtag[0][3] = 1; mdat[0][3] = 16'hAAAA;
      mst[1][3] = 1; mtag[1][3] = 1; mdat[1][3] = 16'hAAAA;
      rmem[7] = 16'hAAAA;

      do_op(2, 0, 7, '0);            // R8 c0 is lowest sharer
      do_op(1, 0, 7, '0);            // R4 S hit after the race

      repeat (2) @(negedge clk);
      wrap_up();
   end

endmodule